// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector with Lock Flag

This block compares two digital loop signals that are already synchronous to a fast sampling clock: a divided feedback signal (`fb_in`) and a divided reference signal (`ref_in`). Only rising edges count. An edge on one input opens an error pulse, and the matching edge on the other input closes it. The width of the pulse, in sampling cycles, is the time between the two edges.

The result is given in two forms. The first is a single three-state error output, encoded on two bits. It drives low while the feedback is ahead or faster, and drives high while the feedback is behind or slower. When the edges coincide it stays at high impedance. The second form is a pair of active-low pulse outputs, one for each direction.

A lock flag is high while no error pulse is open. A pulse no longer than a small tolerance window does not clear it. Charge pumps, loop filters and the oscillator are outside the block.

Top module: `tristate_pfd`

## Requirements
- R1: While reset is asserted and right after it, the error code is 2'b00 (high impedance), `v_n_o` and `r_n_o` are 1 and `lock_o` is 1.
- R2: A rising edge of `fb_in` in the idle state, with no `ref_in` rising edge in the same cycle, makes `v_n_o` 0 and the error code 2'b10 (drive low) from the next cycle.
- R3: A rising edge of `ref_in` in the idle state, with no `fb_in` rising edge in the same cycle, makes `r_n_o` 0 and the error code 2'b11 (drive high) from the next cycle.
- R4: An open pulse stays open until a rising edge of the other input is sampled. The state returns to idle in the next cycle, so the pulse lasts exactly the edge separation in cycles.
- R5: Rising edges of both inputs sampled in the same idle cycle leave the state idle, with the error code at 2'b00.
- R6: Further rising edges of the input that opened the pulse, seen while the pulse is open, change nothing.
- R7: Only 0-to-1 transitions act. A level held high and a 1-to-0 transition have no effect.
- R8: `v_n_o` and `r_n_o` are never 0 together, and the error code never takes the value 2'b01.
- R9: `lock_o` is 1 while idle, and stays 1 through an open pulse of up to `LOCK_WIN` consecutive cycles (default 1). It is 0 in every further cycle of a longer pulse.
- R10: Pulling `rst_n` low clears the outputs to the R1 values at once, without a clock. Release takes effect on the `SYNC_STAGES`-th clock edge after it, plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fb_in | input | 1 | Divided feedback signal, synchronous to `clk` |
| ref_in | input | 1 | Divided reference signal, synchronous to `clk` |
| err_code_o | output | 2 | Three-state error: bit 1 drive enable, bit 0 level |
| v_n_o | output | 1 | Active-low pulse while the feedback is ahead |
| r_n_o | output | 1 | Active-low pulse while the reference is ahead |
| lock_o | output | 1 | Lock indicator |

## Verification
The assertions assume that `fb_in` and `ref_in` already change only in step with the sampling clock, with no metastability to resolve. They also assume that neither input rises while the internal reset release is still working through its stages. The checker's own edge history is cleared by that internal reset, so it agrees with the detector only under that assumption. The stimulus changes both inputs only on falling clock edges, and holds them low around every reset and its release. It then runs square waves with equal periods, with offsets in either direction, with unequal periods, and with a level held high, so that every state transition and the lock tolerance are reached.

// File: rtl/tpfd_pkg.sv
package tpfd_pkg;
  typedef enum logic [1:0] {
    ERR_HIZ  = 2'b00,
    ERR_LOW  = 2'b10,
    ERR_HIGH = 2'b11
  } err_code_e;

  typedef struct packed {
    logic fb_ahead;
    logic ref_ahead;
  } pfd_state_t;

  localparam pfd_state_t PFD_IDLE = '{fb_ahead: 1'b0, ref_ahead: 1'b0};
endpackage

// File: rtl/tpfd_rst_sync.sv
module tpfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tpfd_edge_det.sv
module tpfd_edge_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] last_q;
  logic [WIDTH-1:0] last_d;

  always_comb last_d = sig_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_rise
      assign rise_o[gi] = sig_i[gi] & ~last_q[gi];
    end
  endgenerate
endmodule

// File: rtl/tpfd_core.sv
module tpfd_core
  import tpfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_rise,
  input  logic       ref_rise,
  output pfd_state_t state_q,
  output pfd_state_t state_d
);
  pfd_state_t armed;

  always_comb begin
    armed.fb_ahead  = state_q.fb_ahead  | fb_rise;
    armed.ref_ahead = state_q.ref_ahead | ref_rise;
    if (armed.fb_ahead && armed.ref_ahead) state_d = PFD_IDLE;
    else                                   state_d = armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PFD_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/tpfd_lock.sv
module tpfd_lock #(
  parameter int LOCK_WIN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_next,
  output logic lock_o
);
  localparam int CW = $clog2(LOCK_WIN + 2);
  localparam logic [CW-1:0] SAT = CW'(LOCK_WIN + 1);
  localparam logic [CW-1:0] WIN = CW'(LOCK_WIN);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          run_en;

  always_comb begin
    run_en = active_next ? (run_q != SAT) : (run_q != '0);
    run_d  = active_next ? run_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign lock_o = (run_q <= WIN);
endmodule

// File: rtl/tristate_pfd.sv
module tristate_pfd
  import tpfd_pkg::*;
#(
  parameter int LOCK_WIN    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_in,
  input  logic       ref_in,
  output logic [1:0] err_code_o,
  output logic       v_n_o,
  output logic       r_n_o,
  output logic       lock_o
);
  logic       rst_core_n;
  logic [1:0] rise;
  pfd_state_t st_q;
  pfd_state_t st_d;
  err_code_e  code;

  tpfd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  tpfd_edge_det #(.WIDTH(2)) u_edge (
    .clk(clk), .rst_n(rst_core_n), .sig_i({ref_in, fb_in}), .rise_o(rise)
  );

  tpfd_core u_core (
    .clk(clk), .rst_n(rst_core_n), .fb_rise(rise[0]), .ref_rise(rise[1]),
    .state_q(st_q), .state_d(st_d)
  );

  tpfd_lock #(.LOCK_WIN(LOCK_WIN)) u_lock (
    .clk(clk), .rst_n(rst_core_n),
    .active_next(st_d.fb_ahead | st_d.ref_ahead), .lock_o(lock_o)
  );

  always_comb begin
    unique case (st_q)
      2'b10:   code = ERR_LOW;
      2'b01:   code = ERR_HIGH;
      default: code = ERR_HIZ;
    endcase
  end

  assign err_code_o = code;
  assign v_n_o      = ~st_q.fb_ahead;
  assign r_n_o      = ~st_q.ref_ahead;
endmodule

// File: rtl/tpfd_chk.sv
module tpfd_chk #(
  parameter int LOCK_WIN = 1
) (
  input logic       clk,
  input logic       rst_core_n,
  input logic       fb_in,
  input logic       ref_in,
  input logic [1:0] err_code_o,
  input logic       v_n_o,
  input logic       r_n_o,
  input logic       lock_o
);
  localparam int CW = $clog2(LOCK_WIN + 2);
  localparam logic [CW-1:0] SAT = CW'(LOCK_WIN + 1);
  localparam logic [CW-1:0] WIN = CW'(LOCK_WIN);

  logic          fb_prev, ref_prev;
  logic [CW-1:0] seen;
  logic          fb_edge, ref_edge, idle;

  assign fb_edge  = fb_in & ~fb_prev;
  assign ref_edge = ref_in & ~ref_prev;
  assign idle     = v_n_o & r_n_o;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      fb_prev  <= 1'b0;
      ref_prev <= 1'b0;
      seen     <= '0;
    end else begin
      fb_prev  <= fb_in;
      ref_prev <= ref_in;
      if (idle)             seen <= '0;
      else if (seen != SAT) seen <= seen + 1'b1;
    end
  end

  // R8
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(!v_n_o && !r_n_o));
  // R8
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    err_code_o != 2'b01);
  // R2
  fb_open_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (idle && fb_edge && !ref_edge) |=> (!v_n_o && err_code_o == 2'b10));
  // R3
  ref_open_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (idle && ref_edge && !fb_edge) |=> (!r_n_o && err_code_o == 2'b11));
  // R5
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (idle && ref_edge && fb_edge) |=> (idle && err_code_o == 2'b00));
  // R4
  fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!v_n_o && !ref_edge) |=> !v_n_o);
  // R4
  fb_close_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!v_n_o && ref_edge) |=> idle);
  // R9
  lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    idle |-> lock_o);
  // R9
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!idle && seen >= WIN) |-> !lock_o);
endmodule

bind tristate_pfd tpfd_chk #(.LOCK_WIN(LOCK_WIN)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .fb_in(fb_in), .ref_in(ref_in),
  .err_code_o(err_code_o), .v_n_o(v_n_o), .r_n_o(r_n_o), .lock_o(lock_o)
);

// File: tb/test_tristate_pfd.sv
`timescale 1ns/1ps
module test_tristate_pfd;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fb_in = 1'b0;
  logic       ref_in = 1'b0;
  logic [1:0] err_code_o;
  logic       v_n_o, r_n_o, lock_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural model state
  bit m_v, m_r, m_fbp, m_refp;
  int m_run, m_rel;

  always #10 clk = ~clk;

  tristate_pfd i_tristate_pfd (
    .clk(clk), .rst_n(rst_n), .fb_in(fb_in), .ref_in(ref_in),
    .err_code_o(err_code_o), .v_n_o(v_n_o), .r_n_o(r_n_o), .lock_o(lock_o)
  );

  task automatic model_clear();
    m_v = 0; m_r = 0; m_fbp = 0; m_refp = 0; m_run = 0;
  endtask

  always @(negedge rst_n) begin
    model_clear();
    m_rel = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear();
      m_rel = 0;
    end else if (m_rel < 2) begin
      model_clear();
      m_rel++;
    end else begin
      bit ev, er;
      ev = fb_in && !m_fbp;
      er = ref_in && !m_refp;
      m_fbp = fb_in;
      m_refp = ref_in;
      if ((m_v || ev) && (m_r || er)) begin
        m_v = 0; m_r = 0;
      end else begin
        m_v = m_v || ev;
        m_r = m_r || er;
      end
      m_run = (m_v || m_r) ? m_run + 1 : 0;
    end
  end

  task automatic compare(string t);
    logic [1:0] e_code;
    logic       e_lock;
    e_code = m_v ? 2'b10 : (m_r ? 2'b11 : 2'b00);
    e_lock = (m_run <= 1);
    compared++;
    if (err_code_o !== e_code || v_n_o !== !m_v || r_n_o !== !m_r || lock_o !== e_lock) begin
      mismatched++;
      $display("FAIL %s: got code=%b v_n=%b r_n=%b lock=%b, expected code=%b v_n=%b r_n=%b lock=%b",
               t, err_code_o, v_n_o, r_n_o, lock_o, e_code, !m_v, !m_r, e_lock);
    end
  endtask

  task automatic idle_cycles(int n, string t);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare(t);
      fb_in = 1'b0;
      ref_in = 1'b0;
    end
  endtask

  task automatic waves(int pv, int pr, int ov, int orr, int n, string t);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare(t);
      fb_in  = ((c + ov) % pv) < (pv / 2);
      ref_in = ((c + orr) % pr) < (pr / 2);
    end
  endtask

  initial begin
    #1;
    @(negedge clk);
    compare("R1 reset held");
    @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(6, "R1 after release");
    waves(16, 16, 0, 0, 80, "R5 coincident edges");
    idle_cycles(4, "R5 gap");
    waves(16, 16, 3, 0, 80, "R2 R4 fb leads");
    idle_cycles(4, "R4 gap");
    waves(16, 16, 0, 5, 80, "R3 R4 fb lags");
    idle_cycles(4, "R4 gap");
    waves(16, 16, 1, 0, 64, "R9 one-cycle lead");
    idle_cycles(4, "R9 gap");
    waves(6, 20, 0, 0, 120, "R6 fb faster");
    idle_cycles(4, "R6 gap");
    waves(20, 6, 0, 0, 120, "R6 fb slower");
    idle_cycles(4, "R6 gap");
    // R7: fb held high, then fall, with ref pulsing
    @(negedge clk); compare("R7"); fb_in = 1'b1;
    idle_cycles(0, "R7");
    for (int c = 0; c < 30; c++) begin
      @(negedge clk); compare("R7 level held");
      fb_in = (c < 20);
      ref_in = (c % 8) < 4;
    end
    idle_cycles(6, "R7 gap");
    // R10: async reset during an open pulse
    @(negedge clk); compare("R10 pre"); fb_in = 1'b1;
    @(negedge clk); compare("R10 pre");
    @(negedge clk); compare("R10 open");
    #3 rst_n = 1'b0;
    #2;
    compared++;
    if (err_code_o !== 2'b00 || v_n_o !== 1'b1 || r_n_o !== 1'b1 || lock_o !== 1'b1) begin
      mismatched++;
      $display("FAIL R10 async clear: got code=%b v_n=%b r_n=%b lock=%b, expected code=00 v_n=1 r_n=1 lock=1",
               err_code_o, v_n_o, r_n_o, lock_o);
    end
    fb_in = 1'b0;
    idle_cycles(3, "R10 held");
    @(negedge clk); rst_n = 1'b1; compare("R10 release");
    idle_cycles(4, "R10 after release");
    waves(16, 16, 0, 4, 48, "R10 R3 resume");
    idle_cycles(4, "end");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule